// File: doc/BRIEF.md
# Audio Codec Control Register File

This block is the software-visible control and status store of a stereo audio codec. A link front end, outside this block, deserialises each frame. Once per frame it presents the command word: two tag bits saying whether the address and data slots carry valid content, a read/write flag, a 7-bit register address and 16 bits of write data. The block decodes that command. It updates its registers on writes and captures read data, which the front end then serialises into the status slots of the next input frame.

Besides plain storage, the file does the following:
- It reports subsystem readiness taken live from four status inputs.
- It drives an 8-bit powerdown control vector.
- It enables variable-rate operation. When that mode is off, the converter rate registers are locked at 48000.
- It reports the codec identity, decoded from two active-low strap pins.
- It resets itself in full when any value is written to address 00h.

Top module: `codec_ctrl_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, every register returns to its default: the general registers to 8000h, the powerdown control to 00h, variable-rate mode off, both rates to BB80h, and `sts_valid` to 0.
- R2: A read of address 00h returns the constant 0D50h.
- R3: Odd addresses, and even addresses not listed here, read back 0000h, and writes to them change nothing.
- R4: Address 26h reads {powerdown[7:0], 4'b0000, ready[3:0]}. Ready bit 0 is the reference, bit 1 the mixers, bit 2 the DAC and bit 3 the ADC, taken live from `rdy_in`. A write loads bits 15:8 into `pwr_ctl`, and the other bits are not writable.
- R5: Bit 0 of address 2Ah is the variable-rate enable, seen on `vra_en`. The other bits of 2Ah read 0.
- R6: The DAC rate register (2Ch) and the ADC rate register (32h) accept writes only while variable-rate mode is on. Writing 0 to bit 0 of 2Ah forces both rates back to BB80h. `dac_rate` and `adc_rate` show the stored values.
- R7: Address 28h reads {~id_n[1:0], 13'b0, 1'b1}, taken from the pins at read time. `codec_id` is ~id_n, registered once.
- R8: Writing any value to address 00h returns every register to its R1 default at the next edge.
- R9: A write takes effect only in a cycle with `frame_stb`, `tag_addr` and `tag_data` all high and `cmd_rd` low. Any other command state leaves all registers unchanged.
- R10: A cycle with `frame_stb`, `tag_addr` and `cmd_rd` high makes the response outputs take the register content at the next edge: `sts_valid` 1, `sts_addr` and `sts_data`. They hold until the next `frame_stb`. A `frame_stb` that carries no read clears `sts_valid`.
- R11: The NUM_GEN general registers at addresses 02h, 04h, … 2·NUM_GEN are fully writable 16-bit storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| frame_stb | input | 1 | One-cycle marker of a decoded output frame |
| tag_addr | input | 1 | Address slot tagged valid |
| tag_data | input | 1 | Data slot tagged valid |
| cmd_rd | input | 1 | 1 = read command, 0 = write |
| cmd_addr | input | 7 | Register address |
| cmd_wdata | input | 16 | Write data |
| rdy_in | input | 4 | Live subsystem ready flags |
| id_n | input | 2 | Active-low identity straps |
| sts_valid | output | 1 | Response holds read data |
| sts_addr | output | 7 | Address echoed with the response |
| sts_data | output | 16 | Read data for the status slot |
| pwr_ctl | output | 8 | Powerdown control bits |
| vra_en | output | 1 | Variable-rate mode enabled |
| dac_rate | output | 16 | DAC sample rate |
| adc_rate | output | 16 | ADC sample rate |
| codec_id | output | 2 | Decoded codec identity |

## Verification
The bench probes the following corner cases:
- A rate write while variable-rate mode is off. A design that stored it would move `dac_rate` away from BB80h.
- A write carrying only the address tag. A design that ignored the data tag would corrupt the powerdown bits.
- A write to 00h. Any register left out of the reset would keep its stale value.
- Odd and unlisted addresses. A design with partial decoding would alias them onto real registers and read back non-zero data.
- The live ready bits and the inverted identity pins. A read of a stale copy, or a polarity slip, shows up at once against the reference model.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;
  localparam int AW = 7;
  localparam int DW = 16;

  localparam logic [AW-1:0] A_RESET   = 7'h00;
  localparam logic [AW-1:0] A_PWR     = 7'h26;
  localparam logic [AW-1:0] A_EXTID   = 7'h28;
  localparam logic [AW-1:0] A_EXTCTL  = 7'h2A;
  localparam logic [AW-1:0] A_DACRATE = 7'h2C;
  localparam logic [AW-1:0] A_ADCRATE = 7'h32;

  localparam logic [DW-1:0] CAPS_WORD = 16'h0D50;
  localparam logic [DW-1:0] RATE_48K  = 16'hBB80;

  typedef struct packed {
    logic [7:0]    pwr;
    logic          vra;
    logic [DW-1:0] dac;
    logic [DW-1:0] adc;
  } ctl_t;
endpackage

// File: rtl/codec_cmd_decode.sv
module codec_cmd_decode
  import codec_regs_pkg::*;
(
  input  logic          frame_stb,
  input  logic          tag_addr,
  input  logic          tag_data,
  input  logic          cmd_rd,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          wr_stb,
  output logic          rd_stb,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata
);
  // A write needs both slots tagged; a read needs only the address slot.
  always_comb begin
    wr_stb = frame_stb & tag_addr & tag_data & ~cmd_rd;
    rd_stb = frame_stb & tag_addr & cmd_rd;
    addr   = cmd_addr;
    wdata  = cmd_wdata;
  end
endmodule

// File: rtl/codec_reg_bank.sv
module codec_reg_bank
  import codec_regs_pkg::*;
#(
  parameter int            NUM_GEN     = 8,
  parameter logic [DW-1:0] GEN_DEFAULT = 16'h8000
)(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_stb,
  input  logic [AW-1:0]               addr,
  input  logic [DW-1:0]               wdata,
  output ctl_t                        ctl,
  output logic [NUM_GEN-1:0][DW-1:0]  gen_q
);
  logic reg_reset;
  assign reg_reset = wr_stb && (addr == A_RESET);

  genvar g;
  generate
    for (g = 0; g < NUM_GEN; g++) begin : g_gen
      logic hit;
      assign hit = wr_stb && (addr == AW'(2 * (g + 1)));
      always_ff @(posedge clk) begin
        if (rst || reg_reset) gen_q[g] <= GEN_DEFAULT;
        else if (hit)         gen_q[g] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || reg_reset) begin
      ctl.pwr <= '0;
      ctl.vra <= 1'b0;
      ctl.dac <= RATE_48K;
      ctl.adc <= RATE_48K;
    end else if (wr_stb) begin
      case (addr)
        A_PWR:    ctl.pwr <= wdata[15:8];
        A_EXTCTL: begin
          ctl.vra <= wdata[0];
          if (!wdata[0]) begin
            ctl.dac <= RATE_48K;
            ctl.adc <= RATE_48K;
          end
        end
        A_DACRATE: if (ctl.vra) ctl.dac <= wdata;
        A_ADCRATE: if (ctl.vra) ctl.adc <= wdata;
        default: ;
      endcase
    end
  end

  AST_RATE_LOCK: assert property (@(posedge clk) disable iff (rst)
    !ctl.vra |-> (ctl.dac == RATE_48K && ctl.adc == RATE_48K)); // R6
  AST_REG_RESET: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && addr == A_RESET) |=> (ctl.pwr == 8'h00 && !ctl.vra && ctl.dac == RATE_48K)); // R8
  AST_NO_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> ($stable(ctl.pwr) && $stable(ctl.vra))); // R9
endmodule

// File: rtl/codec_rsp_mux.sv
module codec_rsp_mux
  import codec_regs_pkg::*;
#(
  parameter int NUM_GEN = 8
)(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        frame_stb,
  input  logic                        rd_stb,
  input  logic [AW-1:0]               addr,
  input  ctl_t                        ctl,
  input  logic [NUM_GEN-1:0][DW-1:0]  gen_q,
  input  logic [3:0]                  rdy_in,
  input  logic [1:0]                  id_n,
  output logic                        sts_valid,
  output logic [AW-1:0]               sts_addr,
  output logic [DW-1:0]               sts_data
);
  logic [DW-1:0] rdata;

  always_comb begin
    rdata = '0;
    case (addr)
      A_RESET:   rdata = CAPS_WORD;
      A_PWR:     rdata = {ctl.pwr, 4'b0000, rdy_in};
      A_EXTID:   rdata = {~id_n, 13'b0, 1'b1};
      A_EXTCTL:  rdata = {15'b0, ctl.vra};
      A_DACRATE: rdata = ctl.dac;
      A_ADCRATE: rdata = ctl.adc;
      default: begin
        for (int g = 0; g < NUM_GEN; g++)
          if (addr == AW'(2 * (g + 1))) rdata = gen_q[g];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_valid <= 1'b0;
      sts_addr  <= '0;
      sts_data  <= '0;
    end else if (frame_stb) begin
      sts_valid <= rd_stb;
      if (rd_stb) begin
        sts_addr <= addr;
        sts_data <= rdata;
      end
    end
  end

  AST_CAPS_READ: assert property (@(posedge clk) disable iff (rst)
    (sts_valid && sts_addr == A_RESET) |-> (sts_data == CAPS_WORD)); // R2
  AST_ODD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sts_valid && sts_addr[0]) |-> (sts_data == '0)); // R3
endmodule

// File: rtl/codec_ctrl_regfile.sv
module codec_ctrl_regfile
  import codec_regs_pkg::*;
#(
  parameter int            NUM_GEN     = 8,
  parameter logic [15:0]   GEN_DEFAULT = 16'h8000
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        frame_stb,
  input  logic        tag_addr,
  input  logic        tag_data,
  input  logic        cmd_rd,
  input  logic [6:0]  cmd_addr,
  input  logic [15:0] cmd_wdata,
  input  logic [3:0]  rdy_in,
  input  logic [1:0]  id_n,
  output logic        sts_valid,
  output logic [6:0]  sts_addr,
  output logic [15:0] sts_data,
  output logic [7:0]  pwr_ctl,
  output logic        vra_en,
  output logic [15:0] dac_rate,
  output logic [15:0] adc_rate,
  output logic [1:0]  codec_id
);
  logic                       wr_stb, rd_stb;
  logic [AW-1:0]              addr;
  logic [DW-1:0]              wdata;
  ctl_t                       ctl;
  logic [NUM_GEN-1:0][DW-1:0] gen_q;

  codec_cmd_decode u_dec (
    .frame_stb(frame_stb), .tag_addr(tag_addr), .tag_data(tag_data),
    .cmd_rd(cmd_rd), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .addr(addr), .wdata(wdata)
  );

  codec_reg_bank #(.NUM_GEN(NUM_GEN), .GEN_DEFAULT(GEN_DEFAULT)) u_bank (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .addr(addr), .wdata(wdata),
    .ctl(ctl), .gen_q(gen_q)
  );

  codec_rsp_mux #(.NUM_GEN(NUM_GEN)) u_rsp (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .rd_stb(rd_stb),
    .addr(addr), .ctl(ctl), .gen_q(gen_q), .rdy_in(rdy_in), .id_n(id_n),
    .sts_valid(sts_valid), .sts_addr(sts_addr), .sts_data(sts_data)
  );

  always_ff @(posedge clk) begin
    if (rst) codec_id <= 2'b00;
    else     codec_id <= ~id_n;
  end

  assign pwr_ctl  = ctl.pwr;
  assign vra_en   = ctl.vra;
  assign dac_rate = ctl.dac;
  assign adc_rate = ctl.adc;
endmodule

// File: tb/codec_ctrl_regfile_test.sv
module codec_ctrl_regfile_test;
  localparam int NG = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_stb = 1'b0, tag_addr = 1'b0, tag_data = 1'b0, cmd_rd = 1'b0;
  logic [6:0]  cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic [3:0]  rdy_in = '0;
  logic [1:0]  id_n = 2'b11;
  logic        sts_valid, vra_en;
  logic [6:0]  sts_addr;
  logic [15:0] sts_data, dac_rate, adc_rate;
  logic [7:0]  pwr_ctl;
  logic [1:0]  codec_id;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  codec_ctrl_regfile uut (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .tag_addr(tag_addr),
    .tag_data(tag_data), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rdy_in(rdy_in), .id_n(id_n),
    .sts_valid(sts_valid), .sts_addr(sts_addr), .sts_data(sts_data),
    .pwr_ctl(pwr_ctl), .vra_en(vra_en), .dac_rate(dac_rate),
    .adc_rate(adc_rate), .codec_id(codec_id)
  );

  // Behavioural reference model
  logic [15:0] m_gen [NG];
  logic [7:0]  m_pr;
  logic        m_vra, m_sv;
  logic [15:0] m_dac, m_adc, m_sd;
  logic [6:0]  m_sa;
  logic [1:0]  m_id;

  function automatic logic [15:0] mread(input logic [6:0] a);
    if (a[0]) return 16'h0000;
    if (a == 7'h00) return 16'h0D50;
    if (a == 7'h26) return {m_pr, 4'b0, rdy_in};
    if (a == 7'h28) return {~id_n, 13'b0, 1'b1};
    if (a == 7'h2A) return {15'b0, m_vra};
    if (a == 7'h2C) return m_dac;
    if (a == 7'h32) return m_adc;
    if (a >= 2 && a <= 2 * NG) return m_gen[a / 2 - 1];
    return 16'h0000;
  endfunction

  task automatic mdefaults();
    for (int i = 0; i < NG; i++) m_gen[i] = 16'h8000;
    m_pr = 8'h00; m_vra = 1'b0; m_dac = 16'hBB80; m_adc = 16'hBB80;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mdefaults();
      m_sv = 0; m_sa = 0; m_sd = 0; m_id = 0;
    end else begin
      m_id = ~id_n;
      if (frame_stb) begin
        if (tag_addr && cmd_rd) begin
          m_sv = 1; m_sa = cmd_addr; m_sd = mread(cmd_addr);
        end else m_sv = 0;
        if (tag_addr && tag_data && !cmd_rd) begin
          if (cmd_addr == 7'h00) mdefaults();
          else if (cmd_addr == 7'h26) m_pr = cmd_wdata[15:8];
          else if (cmd_addr == 7'h2A) begin
            m_vra = cmd_wdata[0];
            if (!cmd_wdata[0]) begin m_dac = 16'hBB80; m_adc = 16'hBB80; end
          end
          else if (cmd_addr == 7'h2C) begin if (m_vra) m_dac = cmd_wdata; end
          else if (cmd_addr == 7'h32) begin if (m_vra) m_adc = cmd_wdata; end
          else if (!cmd_addr[0] && cmd_addr >= 2 && cmd_addr <= 2 * NG)
            m_gen[cmd_addr / 2 - 1] = cmd_wdata;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R4 pwr_ctl", 32'(pwr_ctl), 32'(m_pr));
      chk("R5 vra_en", 32'(vra_en), 32'(m_vra));
      chk("R6 rates", {dac_rate, adc_rate}, {m_dac, m_adc});
      chk("R7 codec_id", 32'(codec_id), 32'(m_id));
      chk("R10 sts_valid", 32'(sts_valid), 32'(m_sv));
      if (m_sv) chk("R10 sts_addr/data", {9'b0, sts_addr, sts_data}, {9'b0, m_sa, m_sd});
    end
  end

  task automatic frame(input logic ta, input logic td, input logic rd,
                       input logic [6:0] a, input logic [15:0] d, input logic stb = 1'b1);
    @(negedge clk);
    frame_stb = stb; tag_addr = ta; tag_data = td; cmd_rd = rd;
    cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    frame_stb = 0; tag_addr = 0; tag_data = 0; cmd_rd = 0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    frame(1, 1, 0, a, d);
  endtask

  task automatic rd_expect(input logic [6:0] a, input logic [15:0] exp, input string tag);
    frame(1, 0, 1, a, 16'h0);
    chk(tag, {15'b0, sts_valid, sts_data}, {15'b0, 1'b1, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R1 reset pwr/vra", {23'b0, pwr_ctl, vra_en}, 32'h0);
    chk("R1 reset rates", {dac_rate, adc_rate}, {16'hBB80, 16'hBB80});
    chk("R1 reset sts_valid", 32'(sts_valid), 32'h0);

    rd_expect(7'h00, 16'h0D50, "R2 caps word");
    rd_expect(7'h02, 16'h8000, "R1 general default");
    wr(7'h02, 16'h1234);
    rd_expect(7'h02, 16'h1234, "R11 general write");
    wr(7'h10, 16'hBEEF);
    rd_expect(7'h10, 16'hBEEF, "R11 last general register");
    rd_expect(7'h03, 16'h0000, "R3 odd read");
    wr(7'h05, 16'hFFFF);
    rd_expect(7'h04, 16'h8000, "R3 odd write ignored");
    wr(7'h7E, 16'hFFFF);
    rd_expect(7'h7E, 16'h0000, "R3 reserved read");

    rdy_in = 4'b1010;
    wr(7'h26, 16'hFFFF);
    chk("R4 pwr_ctl write", 32'(pwr_ctl), 32'hFF);
    rd_expect(7'h26, 16'hFF0A, "R4 status mix");

    rd_expect(7'h2A, 16'h0000, "R5 ext ctl default");
    wr(7'h2C, 16'h1F40);
    rd_expect(7'h2C, 16'hBB80, "R6 rate locked");
    wr(7'h2A, 16'hFFFF);
    chk("R5 vra on", 32'(vra_en), 32'h1);
    rd_expect(7'h2A, 16'h0001, "R5 upper bits zero");
    wr(7'h2C, 16'h1F40);
    wr(7'h32, 16'h5622);
    chk("R6 rates writable", {dac_rate, adc_rate}, {16'h1F40, 16'h5622});
    rd_expect(7'h32, 16'h5622, "R6 adc rate read");
    wr(7'h2A, 16'h0000);
    chk("R6 rates forced", {dac_rate, adc_rate}, {16'hBB80, 16'hBB80});

    id_n = 2'b01;
    rd_expect(7'h28, 16'h8001, "R7 identity read");
    chk("R7 codec_id", 32'(codec_id), 32'h2);

    frame(1, 0, 0, 7'h26, 16'h0000);
    chk("R9 untagged data ignored", 32'(pwr_ctl), 32'hFF);
    frame(1, 1, 0, 7'h26, 16'h0000, 1'b0);
    chk("R9 no strobe ignored", 32'(pwr_ctl), 32'hFF);

    wr(7'h00, 16'h0000);
    chk("R8 register reset", {23'b0, pwr_ctl, vra_en}, 32'h0);
    rd_expect(7'h02, 16'h8000, "R8 general reset");
    frame(0, 0, 0, 7'h00, 16'h0);
    chk("R10 valid cleared", 32'(sts_valid), 32'h0);

    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[3:0])
        4'd0: a = 7'h00;
        4'd1, 4'd2: a = 7'h26;
        4'd3: a = 7'h28;
        4'd4, 4'd5: a = 7'h2A;
        4'd6: a = 7'h2C;
        4'd7: a = 7'h32;
        default: a = lfsr[10:4];
      endcase
      if (a == 7'h00 && lfsr[9]) a = 7'h01;
      rdy_in = lfsr[14:11];
      id_n = lfsr[1:0];
      frame(lfsr[15], lfsr[6], lfsr[7], a, {lfsr[7:0], lfsr[15:8]}, lfsr[12] | lfsr[2]);
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule